// File: doc/BRIEF.md
# Dual L1 Ownership Coherence Controller

This block keeps the private L1 data caches of two cores on one die coherent under the MESI protocol. It tracks, for a small set of line slots, the coherence state each cache holds and one flag per line marking it as possibly held by an agent beyond the die. Each core presents a read or write request for a line slot and holds it until it receives a one-cycle completion pulse. Only one transaction is in flight at a time. When both cores ask in the same cycle, a round-robin arbiter picks the winner, and the other request waits until the winner completes.

A write needs ownership. A line already held Exclusive or Modified is written at once. Otherwise the block performs a read-for-ownership (RFO). If the only other copy is in the sibling L1, the RFO is settled on die, with a transfer strobe when the sibling held dirty data. The external bus, a request/acknowledge handshake, is used only when the line may be held off die or no copy exists on die. Data arrays, replacement and the shared-cache datapath are outside the block.

Top module: `dual_l1_coherence`

## Requirements
- R1: State codes per cache line are Invalid=0, Shared=1, Exclusive=2, Modified=3. After reset every line is Invalid in both caches with the off-die flag clear, `done_o` is 0 and `bus_req_o` is low.
- R2: A read by a core whose own copy is not Invalid completes without a bus request and leaves all states unchanged.
- R3: A read miss while the sibling holds the line completes on die and leaves both copies Shared. `xfer_o` pulses with the completion exactly when the sibling copy was Modified.
- R4: A read miss with no copy on die raises a bus request with `bus_rfo_o`=0. The fill is Exclusive with the off-die flag clear when `bus_shared_i` is 0 at acknowledge. When `bus_shared_i` is 1, the fill is Shared with the flag set.
- R5: A write to an Exclusive copy turns it Modified without a bus request. A write to a Modified copy leaves it Modified.
- R6: A write from Shared or Invalid, with the off-die flag clear and a sibling copy present, completes on die. The writer ends Modified and the sibling Invalid, and `xfer_o` pulses exactly when the sibling was Modified.
- R7: A write from Shared or Invalid raises a bus request with `bus_rfo_o`=1 when the off-die flag is set or neither cache holds the line. After acknowledge the writer is Modified, the sibling is Invalid and the flag is clear.
- R8: While `bus_ack_i` is low, `bus_req_o` stays high with `bus_line_o` and `bus_rfo_o` unchanged. The completion pulse follows in the cycle after the acknowledge.
- R9: `done_o` carries at most one bit, high for exactly one cycle. A request that needs no bus completes in the cycle after it is first presented.
- R10: Same-cycle requests are granted round robin. Priority moves to the core after the last winner, and core 0 has priority after reset. The losing request is served right after the winner completes.
- R11: A line held Exclusive or Modified in one cache is Invalid in the other, and a line whose off-die flag is set is neither Exclusive nor Modified in either cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 2 | Per-core request valid, held until done |
| req_write_i | input | 2 | Per-core request is a write |
| req_line_i | input | 2*LW | Per-core line slot, core 0 in the low bits |
| done_o | output | 2 | Per-core completion pulse |
| xfer_o | output | 1 | Dirty sibling data supplied on die, with the completion |
| bus_req_o | output | 1 | External bus request |
| bus_rfo_o | output | 1 | Bus request is an ownership read |
| bus_line_o | output | LW | Line slot of the bus request |
| bus_ack_i | input | 1 | Bus acknowledge |
| bus_shared_i | input | 1 | Off-die agent keeps a copy, valid with acknowledge |
| st_line_i | input | LW | Line slot to observe |
| st_core0_o | output | 2 | Core 0 state of observed line |
| st_core1_o | output | 2 | Core 1 state of observed line |
| st_ext_o | output | 1 | Off-die flag of observed line |

## Verification
On every cycle the checker enforces several rules. It checks the single-owner and off-die-flag invariants on whatever line is being observed. It checks that a bus request holds its line and kind until acknowledged and that completion follows the acknowledge. It checks that completion pulses are single-bit, one-cycle events with no bus request active, and that a transfer strobe only comes with an on-die completion. Whether a given request goes on die or onto the bus, which fill state results, the transfer strobe on dirty siblings and the round-robin order under simultaneous RFOs depend on request history. Only the bench's scenario sequences reveal those.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int NCORE = 2;

  typedef enum logic [1:0] {
    MESI_I = 2'd0,
    MESI_S = 2'd1,
    MESI_E = 2'd2,
    MESI_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_BUS  = 2'd1,
    CTL_RESP = 2'd2
  } ctl_e;
endpackage

// File: rtl/coh_arb.sv
module coh_arb #(
  parameter  int NREQ = 2,
  localparam int IW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] req_i,
  input  logic            adv_i,
  output logic            gnt_any_o,
  output logic [IW-1:0]   gnt_idx_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    gnt_any_o = 1'b0;
    gnt_idx_o = '0;
    for (int k = 0; k < NREQ; k++) begin
      int c;
      c = (int'(ptr_q) + k) % NREQ;
      if (!gnt_any_o && req_i[c]) begin
        gnt_any_o = 1'b1;
        gnt_idx_o = IW'(c);
      end
    end
  end

  // priority moves just past the last winner
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (adv_i && gnt_any_o) begin
      if (int'(gnt_idx_o) == NREQ - 1) ptr_q <= '0;
      else                             ptr_q <= gnt_idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/coh_dir.sv
module coh_dir import coh_pkg::*; #(
  parameter int NLINES = 8,
  parameter int LW     = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          core_i,
  input  logic [LW-1:0] line_i,
  output mesi_e         own_o,
  output mesi_e         sib_o,
  output logic          ext_o,
  input  logic          wr_en_i,
  input  mesi_e         wr_own_i,
  input  mesi_e         wr_sib_i,
  input  logic          wr_ext_i,
  input  logic [LW-1:0] q_line_i,
  output mesi_e         q_st_o [NCORE],
  output logic          q_ext_o
);
  mesi_e              rd_st [NCORE];
  logic [NLINES-1:0]  ext_q;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    mesi_e mem_q [NLINES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NLINES; i++) mem_q[i] <= MESI_I;
      end else if (wr_en_i) begin
        mem_q[line_i] <= (core_i == 1'(c)) ? wr_own_i : wr_sib_i;
      end
    end

    assign rd_st[c]  = mem_q[line_i];
    assign q_st_o[c] = mem_q[q_line_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ext_q         <= '0;
    else if (wr_en_i) ext_q[line_i] <= wr_ext_i;
  end

  assign own_o   = rd_st[core_i];
  assign sib_o   = rd_st[~core_i];
  assign ext_o   = ext_q[line_i];
  assign q_ext_o = ext_q[q_line_i];
endmodule

// File: rtl/coh_ctl.sv
module coh_ctl import coh_pkg::*; #(
  parameter int LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    req_write_i,
  input  logic [LW-1:0] req_line_i [NCORE],
  input  logic          gnt_any_i,
  input  logic          gnt_idx_i,
  output logic          adv_o,
  input  mesi_e         own_i,
  input  mesi_e         sib_i,
  input  logic          ext_i,
  output logic          cur_core_o,
  output logic [LW-1:0] cur_line_o,
  output logic          wr_en_o,
  output mesi_e         wr_own_o,
  output mesi_e         wr_sib_o,
  output logic          wr_ext_o,
  output logic          bus_req_o,
  output logic          bus_rfo_o,
  output logic [LW-1:0] bus_line_o,
  input  logic          bus_ack_i,
  input  logic          bus_shared_i,
  output logic [1:0]    done_o,
  output logic          xfer_o
);
  ctl_e          state_q, state_d;
  logic          core_q;
  logic [LW-1:0] line_q;
  logic          wr_q;
  logic          xfer_q, xfer_d;
  logic          accept;
  logic          cur_wr;

  assign accept     = (state_q == CTL_IDLE) && gnt_any_i;
  assign adv_o      = accept;
  assign cur_core_o = (state_q == CTL_IDLE) ? gnt_idx_i : core_q;
  assign cur_line_o = (state_q == CTL_IDLE) ? req_line_i[gnt_idx_i] : line_q;
  assign cur_wr     = (state_q == CTL_IDLE) ? req_write_i[gnt_idx_i] : wr_q;

  always_comb begin
    state_d  = state_q;
    wr_en_o  = 1'b0;
    wr_own_o = own_i;
    wr_sib_o = sib_i;
    wr_ext_o = ext_i;
    xfer_d   = 1'b0;
    unique case (state_q)
      CTL_IDLE: begin
        if (gnt_any_i) begin
          state_d = CTL_RESP;
          if (!cur_wr) begin
            if (own_i == MESI_I) begin
              if (sib_i != MESI_I) begin
                // on-die fill from sibling
                wr_en_o  = 1'b1;
                wr_own_o = MESI_S;
                wr_sib_o = MESI_S;
                xfer_d   = (sib_i == MESI_M);
              end else begin
                state_d = CTL_BUS;
              end
            end
          end else begin
            if (own_i == MESI_E) begin
              wr_en_o  = 1'b1;
              wr_own_o = MESI_M;
            end else if (own_i != MESI_M) begin
              if (ext_i || (own_i == MESI_I && sib_i == MESI_I)) begin
                state_d = CTL_BUS;
              end else begin
                // ownership settled on die
                wr_en_o  = 1'b1;
                wr_own_o = MESI_M;
                wr_sib_o = MESI_I;
                wr_ext_o = 1'b0;
                xfer_d   = (sib_i == MESI_M);
              end
            end
          end
        end
      end
      CTL_BUS: begin
        if (bus_ack_i) begin
          state_d = CTL_RESP;
          wr_en_o = 1'b1;
          if (wr_q) begin
            wr_own_o = MESI_M;
            wr_sib_o = MESI_I;
            wr_ext_o = 1'b0;
          end else begin
            wr_own_o = bus_shared_i ? MESI_S : MESI_E;
            wr_ext_o = bus_shared_i;
          end
        end
      end
      default: state_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CTL_IDLE;
      core_q  <= 1'b0;
      line_q  <= '0;
      wr_q    <= 1'b0;
      xfer_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        core_q <= gnt_idx_i;
        line_q <= req_line_i[gnt_idx_i];
        wr_q   <= req_write_i[gnt_idx_i];
        xfer_q <= xfer_d;
      end
    end
  end

  assign bus_req_o  = (state_q == CTL_BUS);
  assign bus_rfo_o  = (state_q == CTL_BUS) && wr_q;
  assign bus_line_o = line_q;
  assign done_o     = (state_q == CTL_RESP) ? (2'b01 << core_q) : 2'b00;
  assign xfer_o     = (state_q == CTL_RESP) && xfer_q;
endmodule

// File: rtl/dual_l1_coherence.sv
module dual_l1_coherence import coh_pkg::*; #(
  parameter  int NLINES = 8,
  localparam int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      req_valid_i,
  input  logic [1:0]      req_write_i,
  input  logic [2*LW-1:0] req_line_i,
  output logic [1:0]      done_o,
  output logic            xfer_o,
  output logic            bus_req_o,
  output logic            bus_rfo_o,
  output logic [LW-1:0]   bus_line_o,
  input  logic            bus_ack_i,
  input  logic            bus_shared_i,
  input  logic [LW-1:0]   st_line_i,
  output logic [1:0]      st_core0_o,
  output logic [1:0]      st_core1_o,
  output logic            st_ext_o
);
  logic [LW-1:0] line_arr [NCORE];
  logic          gnt_any, gnt_idx, adv;
  logic          cur_core;
  logic [LW-1:0] cur_line;
  mesi_e         own_st, sib_st;
  logic          ext_flag;
  logic          wr_en, wr_ext;
  mesi_e         wr_own, wr_sib;
  mesi_e         q_st [NCORE];

  for (genvar c = 0; c < NCORE; c++) begin : g_line
    assign line_arr[c] = req_line_i[c*LW +: LW];
  end

  coh_arb #(.NREQ(NCORE)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_valid_i),
    .adv_i     (adv),
    .gnt_any_o (gnt_any),
    .gnt_idx_o (gnt_idx)
  );

  coh_dir #(.NLINES(NLINES), .LW(LW)) u_dir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .core_i   (cur_core),
    .line_i   (cur_line),
    .own_o    (own_st),
    .sib_o    (sib_st),
    .ext_o    (ext_flag),
    .wr_en_i  (wr_en),
    .wr_own_i (wr_own),
    .wr_sib_i (wr_sib),
    .wr_ext_i (wr_ext),
    .q_line_i (st_line_i),
    .q_st_o   (q_st),
    .q_ext_o  (st_ext_o)
  );

  coh_ctl #(.LW(LW)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_write_i  (req_write_i),
    .req_line_i   (line_arr),
    .gnt_any_i    (gnt_any),
    .gnt_idx_i    (gnt_idx),
    .adv_o        (adv),
    .own_i        (own_st),
    .sib_i        (sib_st),
    .ext_i        (ext_flag),
    .cur_core_o   (cur_core),
    .cur_line_o   (cur_line),
    .wr_en_o      (wr_en),
    .wr_own_o     (wr_own),
    .wr_sib_o     (wr_sib),
    .wr_ext_o     (wr_ext),
    .bus_req_o    (bus_req_o),
    .bus_rfo_o    (bus_rfo_o),
    .bus_line_o   (bus_line_o),
    .bus_ack_i    (bus_ack_i),
    .bus_shared_i (bus_shared_i),
    .done_o       (done_o),
    .xfer_o       (xfer_o)
  );

  assign st_core0_o = q_st[0];
  assign st_core1_o = q_st[1];
endmodule

// File: rtl/dual_l1_coherence_chk.sv
module dual_l1_coherence_chk #(
  parameter  int NLINES = 8,
  localparam int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    done_o,
  input logic          xfer_o,
  input logic          bus_req_o,
  input logic          bus_rfo_o,
  input logic [LW-1:0] bus_line_o,
  input logic          bus_ack_i,
  input logic [1:0]    st_core0_o,
  input logic [1:0]    st_core1_o,
  input logic          st_ext_o
);
  a_r8_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_line_o) && $stable(bus_rfo_o));

  a_r8_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |=> done_o != 2'b00);

  a_r9_done_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o) && !(done_o != 2'b00 && bus_req_o));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o != 2'b00 |=> done_o == 2'b00);

  a_r3_xfer_on_die: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> !bus_req_o && $countones(done_o) == 1);

  a_r11_owner0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_core0_o >= 2'd2 |-> st_core1_o == 2'd0);

  a_r11_owner1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_core1_o >= 2'd2 |-> st_core0_o == 2'd0);

  a_r11_ext_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ext_o |-> st_core0_o < 2'd2 && st_core1_o < 2'd2);
endmodule

bind dual_l1_coherence dual_l1_coherence_chk #(.NLINES(NLINES)) u_chk (.*);

// File: tb/dual_l1_coherence_tb.sv
module dual_l1_coherence_tb;
  localparam int NLINES = 8;
  localparam int LW     = 3;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [1:0]      req_valid_i = '0;
  logic [1:0]      req_write_i = '0;
  logic [2*LW-1:0] req_line_i = '0;
  logic [1:0]      done_o;
  logic            xfer_o;
  logic            bus_req_o, bus_rfo_o;
  logic [LW-1:0]   bus_line_o;
  logic            bus_ack_i = 1'b0;
  logic            bus_shared_i = 1'b0;
  logic [LW-1:0]   st_line_i = '0;
  logic [1:0]      st_core0_o, st_core1_o;
  logic            st_ext_o;

  always #5 clk_i = ~clk_i;

  dual_l1_coherence #(.NLINES(NLINES)) u_dut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int            first_done;
  int            lat;
  bit            bus_seen, bus_rfo_seen, xfer_seen;
  logic [LW-1:0] bus_line_seen;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // present requests, answer the bus after two waiting cycles, collect results
  task automatic drive(input logic [1:0] m, input logic [1:0] w,
                       input logic [LW-1:0] l0, input logic [LW-1:0] l1,
                       input logic sh);
    int cyc = 0;
    int wcnt = 0;
    logic [1:0] pend;
    @(negedge clk_i);
    req_write_i = w;
    req_line_i  = {l1, l0};
    req_valid_i = m;
    pend = m;
    first_done = -1; lat = 0;
    bus_seen = 0; bus_rfo_seen = 0; xfer_seen = 0; bus_line_seen = '0;
    while (pend != 2'b00 && cyc < 200) begin
      @(negedge clk_i);
      cyc++;
      if (bus_ack_i) begin
        bus_ack_i = 1'b0;
      end else if (bus_req_o) begin
        bus_seen = 1; bus_rfo_seen = bus_rfo_o; bus_line_seen = bus_line_o;
        wcnt++;
        if (wcnt >= 2) begin
          bus_ack_i = 1'b1; bus_shared_i = sh; wcnt = 0;
        end
      end
      if (xfer_o) xfer_seen = 1;
      for (int k = 0; k < 2; k++) begin
        if (pend[k] && done_o[k]) begin
          pend[k] = 1'b0;
          req_valid_i[k] = 1'b0;
          if (first_done < 0) first_done = k;
          if (lat == 0) lat = cyc;
        end
      end
    end
    chk("R9 request completes", int'(pend), 0);
    req_valid_i = 2'b00;
  endtask

  task automatic query(input logic [LW-1:0] l, output int s0, output int s1, output int ex);
    @(negedge clk_i);
    st_line_i = l;
    #1;
    s0 = st_core0_o; s1 = st_core1_o; ex = st_ext_o;
  endtask

  typedef struct packed {
    logic [3:0]    rq;
    logic          core;
    logic          wr;
    logic [LW-1:0] line;
    logic [1:0]    bus;   // 0 none, 1 read, 2 ownership read
    logic          sh;
    logic          xf;
    logic [1:0]    e0;
    logic [1:0]    e1;
    logic          ex;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{4'd4,  1'b0, 1'b0, 3'd0, 2'd1, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0}, // R4 fill E
    '{4'd5,  1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0}, // R5 E->M
    '{4'd3,  1'b1, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 2'd1, 2'd1, 1'b0}, // R3 dirty sibling
    '{4'd6,  1'b1, 1'b1, 3'd0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0}, // R6 from S
    '{4'd6,  1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 1'b1, 2'd3, 2'd0, 1'b0}, // R6 from I, dirty
    '{4'd4,  1'b1, 1'b0, 3'd1, 2'd1, 1'b1, 1'b0, 2'd0, 2'd1, 1'b1}, // R4 fill S, flag
    '{4'd3,  1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b1}, // R3 clean sibling
    '{4'd7,  1'b0, 1'b1, 3'd1, 2'd2, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0}, // R7 flag set
    '{4'd7,  1'b1, 1'b1, 3'd2, 2'd2, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0}, // R7 no copy
    '{4'd4,  1'b0, 1'b0, 3'd3, 2'd1, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0}, // R4
    '{4'd3,  1'b1, 1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0}, // R3 sibling E
    '{4'd2,  1'b1, 1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0}, // R2 hit
    '{4'd7,  1'b0, 1'b1, 3'd7, 2'd2, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0}, // R7 last slot
    '{4'd3,  1'b1, 1'b0, 3'd7, 2'd0, 1'b0, 1'b1, 2'd1, 2'd1, 1'b0}, // R3
    '{4'd2,  1'b0, 1'b0, 3'd7, 2'd0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0}, // R2 hit
    '{4'd5,  1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0}  // R5 M stays
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int s0, s1, ex;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 bus_req after reset", int'(bus_req_o), 0);
    for (int l = 0; l < NLINES; l++) begin
      query(LW'(l), s0, s1, ex);
      chk("R1 reset line state", s0 * 8 + s1 * 2 + ex, 0);
    end

    foreach (VEC[i]) begin
      vec_t v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v.rq, i);
      if (v.core) drive(2'b10, {v.wr, 1'b0}, '0, v.line, v.sh);
      else        drive(2'b01, {1'b0, v.wr}, v.line, '0, v.sh);
      chk({tag, " bus used"}, int'(bus_seen), int'(v.bus != 2'd0));
      if (v.bus != 2'd0) begin
        chk({tag, " bus kind (R8)"}, int'(bus_rfo_seen), int'(v.bus == 2'd2));
        chk({tag, " bus line (R8)"}, int'(bus_line_seen), int'(v.line));
      end else begin
        chk({tag, " latency (R9)"}, lat, 1);
      end
      chk({tag, " xfer"}, int'(xfer_seen), int'(v.xf));
      query(v.line, s0, s1, ex);
      chk({tag, " core0 state"}, s0, int'(v.e0));
      chk({tag, " core1 state"}, s1, int'(v.e1));
      chk({tag, " off-die flag"}, ex, int'(v.ex));
    end

    // R11 invariants over all slots after the sequence
    for (int l = 0; l < NLINES; l++) begin
      query(LW'(l), s0, s1, ex);
      chk("R11 single owner", int'((s0 >= 2 && s1 != 0) || (s1 >= 2 && s0 != 0)), 0);
      chk("R11 flag only on shared", int'(ex == 1 && (s0 >= 2 || s1 >= 2)), 0);
    end

    // R10: last winner core0, so core1 first; both write slot 5, no copy on die
    drive(2'b11, 2'b11, 3'd5, 3'd5, 1'b0);
    chk("R10 first winner after core0", first_done, 1);
    chk("R10 loser on die with dirty data", int'(xfer_seen), 1);
    query(3'd5, s0, s1, ex);
    chk("R10 final owner core0", s0 * 4 + s1, 12);

    // R10: core1 wins alone, then a tie goes to core0
    drive(2'b10, 2'b00, '0, 3'd6, 1'b0);
    drive(2'b11, 2'b11, 3'd6, 3'd6, 1'b0);
    chk("R10 first winner after core1", first_done, 0);
    chk("R10 both on die, no bus", int'(bus_seen), 0);
    query(3'd6, s0, s1, ex);
    chk("R10 final owner core1", s0 * 4 + s1, 3);

    // R1 reset mid-run clears state
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    query(3'd6, s0, s1, ex);
    chk("R1 reset clears slot 6", s0 * 8 + s1 * 2 + ex, 0);
    query(3'd1, s0, s1, ex);
    chk("R1 reset clears slot 1", s0 * 8 + s1 * 2 + ex, 0);

    finish_run();
  end
endmodule